// File: doc/BRIEF.md
# AXI Read Latency Monitor

A passive observer placed on the read side of an AXI4 memory-mapped link. It watches the read address and read data handshakes and measures the time from an accepted read request to the first accepted data beat of the response. It never drives any AXI signal. Its inputs are the valid and ready wires of the two read channels.

A free-running timebase advances on every clock. A request event is taken only when the address handshake happens in the first cycle of a valid assertion. The timebase value at that event is queued. A response event is taken only when the data handshake happens in the first cycle of a data valid assertion, which is the first beat of a burst. At a response event the oldest queued timestamp is removed and subtracted from the current timebase. The result is reported with a one-cycle strobe.

Running statistics are kept as plain output ports: the number of samples, the smallest and largest latency, and a wide sum. Software divides the sum by the count to get the mean, and compares the extremes to see the spread over several hundred reads. A synchronous clear restarts a measurement campaign. The timebase is not affected by clear.

Top module: `axiReadLatMon`

## Requirements
- R1: After reset the sample count is 0, the latency sum is 0, the minimum is all ones (0xFFFFFFFF), the maximum is 0, both sticky flags are 0 and the sample strobe is low.
- R2: A request timestamp is queued only at a clock edge where arValid and arReady are both high and arValid was low at the previous edge. An address valid that is held high while waiting for arReady is never timestamped.
- R3: A response event happens only at a clock edge where rValid and rReady are both high and rValid was low at the previous edge. Later beats of the same burst produce no sample. A first beat that waits for rReady also produces no sample.
- R4: For a request event at edge a and its matching response event at edge b, the block outputs the latency b−a, computed modulo 2^32. The value appears with sampleValid high for exactly the one cycle after edge b.
- R5: Up to 8 request timestamps are held. Response events pair with them in first-in, first-out order.
- R6: A request event that arrives while 8 timestamps are held is discarded and sets the sticky overflow flag.
- R7: A response event that arrives while no timestamp is held produces no sample and sets the sticky orphan flag.
- R8: Each sample increments the 32-bit count, adds its latency to the 48-bit sum, and lowers the minimum or raises the maximum when the new latency lies outside them.
- R9: A clear cycle returns the statistics and flags to the R1 state and empties the timestamp queue. A response that arrives after the clear is therefore an orphan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Synchronous restart of statistics, flags and queue |
| arValid | input | 1 | Observed read address valid |
| arReady | input | 1 | Observed read address ready |
| rValid | input | 1 | Observed read data valid |
| rReady | input | 1 | Observed read data ready |
| sampleValid | output | 1 | One-cycle strobe for a new latency |
| sampleLatency | output | 32 | Most recent latency in clocks |
| sampleCount | output | 32 | Number of samples taken |
| minLatency | output | 32 | Smallest latency seen |
| maxLatency | output | 32 | Largest latency seen |
| latencySum | output | 48 | Sum of all latencies |
| overflowFlag | output | 1 | Sticky: a request was dropped because the queue was full |
| orphanFlag | output | 1 | Sticky: a response arrived with the queue empty |

## Verification
Most internal faults show up at the ports on the first response event after the faulty state is created. A pointer or occupancy error pairs a response with the wrong timestamp. That error appears as a wrong sampleLatency in the cycle after the first-beat edge, or as a sample where an orphan was expected. A faulty edge detector shows up on the very next burst, either as extra samples during the beats or as a missing strobe. A statistics fault is visible in the same cycle as the sample that causes it, because count, sum, minimum and maximum are all compared after every strobe.

// File: rtl/latmon_pkg.sv
package latmon_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic clear;  // restart statistics
    logic push;   // store current timebase into queue
    logic pop;    // take oldest timestamp, produce a sample
  } strobe_t;
endpackage

// File: rtl/latmonCtrl.sv
module latmonCtrl
  import latmon_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic arValid,
  input  logic arReady,
  input  logic rValid,
  input  logic rReady,
  output strobe_t strobe,
  output logic [$clog2(DEPTH)-1:0] wrPtr,
  output logic [$clog2(DEPTH)-1:0] rdPtr,
  output logic overflowFlag,
  output logic orphanFlag
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic arValidPrev, rValidPrev;
  logic [LVL_W-1:0] level;
  logic reqEvt, rspEvt, isFull, isEmpty;

  always_comb begin
    reqEvt       = arValid && arReady && !arValidPrev;
    rspEvt       = rValid && rReady && !rValidPrev;
    isFull       = (level == FULL_LVL);
    isEmpty      = (level == '0);
    strobe.clear = clear;
    strobe.push  = reqEvt && !isFull && !clear;
    strobe.pop   = rspEvt && !isEmpty && !clear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arValidPrev  <= 1'b0;
      rValidPrev   <= 1'b0;
      wrPtr        <= '0;
      rdPtr        <= '0;
      level        <= '0;
      overflowFlag <= 1'b0;
      orphanFlag   <= 1'b0;
    end else begin
      arValidPrev <= arValid;
      rValidPrev  <= rValid;
      if (clear) begin
        wrPtr        <= '0;
        rdPtr        <= '0;
        level        <= '0;
        overflowFlag <= 1'b0;
        orphanFlag   <= 1'b0;
      end else begin
        if (strobe.push) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
        if (strobe.pop)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
        if (strobe.push && !strobe.pop)      level <= level + 1'b1;
        else if (!strobe.push && strobe.pop) level <= level - 1'b1;
        if (reqEvt && isFull)  overflowFlag <= 1'b1;
        if (rspEvt && isEmpty) orphanFlag   <= 1'b1;
      end
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_LVL); // R5
  AST_NO_DOUBLE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> !strobe.push); // R2
  AST_NO_DOUBLE_RSP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |=> !strobe.pop); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflowFlag && !clear) |=> overflowFlag); // R6
  AST_ORPHAN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (orphanFlag && !clear) |=> orphanFlag); // R7
endmodule

// File: rtl/latmonDatapath.sv
module latmonDatapath
  import latmon_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TS_W  = 32,
  parameter int CNT_W = 32,
  parameter int SUM_W = 48
) (
  input  logic clk,
  input  logic rstN,
  input  strobe_t strobe,
  input  logic [$clog2(DEPTH)-1:0] wrPtr,
  input  logic [$clog2(DEPTH)-1:0] rdPtr,
  output logic sampleValid,
  output logic [TS_W-1:0] sampleLatency,
  output logic [CNT_W-1:0] sampleCount,
  output logic [TS_W-1:0] minLatency,
  output logic [TS_W-1:0] maxLatency,
  output logic [SUM_W-1:0] latencySum
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [TS_W-1:0] timebase;
  logic [TS_W-1:0] stamps [DEPTH];
  logic [TS_W-1:0] newLat;

  // Free-running timebase, untouched by traffic or clear
  always_ff @(posedge clk) begin
    if (!rstN) timebase <= '0;
    else       timebase <= timebase + 1'b1;
  end

  // Timestamp queue storage, one register per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.push && (wrPtr == PTR_W'(i))) stamps[i] <= timebase;
    end
  end

  // Modular difference survives one timebase wrap
  always_comb newLat = timebase - stamps[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      sampleValid   <= 1'b0;
      sampleLatency <= '0;
      sampleCount   <= '0;
      minLatency    <= '1;
      maxLatency    <= '0;
      latencySum    <= '0;
    end else begin
      sampleValid <= strobe.pop;
      if (strobe.pop) begin
        sampleLatency <= newLat;
        sampleCount   <= sampleCount + 1'b1;
        latencySum    <= latencySum + SUM_W'(newLat);
        if (newLat < minLatency) minLatency <= newLat;
        if (newLat > maxLatency) maxLatency <= newLat;
      end
    end
  end

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !$past(strobe.clear)) |-> sampleCount == $past(sampleCount) + 1'b1); // R8
  AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (sampleCount != '0) |-> minLatency <= maxLatency); // R8
  AST_LAT_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (sampleLatency >= minLatency) && (sampleLatency <= maxLatency)); // R8
endmodule

// File: rtl/axiReadLatMon.sv
module axiReadLatMon
  import latmon_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TS_W  = 32,
  parameter int CNT_W = 32,
  parameter int SUM_W = 48
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic arValid,
  input  logic arReady,
  input  logic rValid,
  input  logic rReady,
  output logic sampleValid,
  output logic [TS_W-1:0] sampleLatency,
  output logic [CNT_W-1:0] sampleCount,
  output logic [TS_W-1:0] minLatency,
  output logic [TS_W-1:0] maxLatency,
  output logic [SUM_W-1:0] latencySum,
  output logic overflowFlag,
  output logic orphanFlag
);
  localparam int PTR_W = $clog2(DEPTH);

  strobe_t strobe;
  logic [PTR_W-1:0] wrPtr, rdPtr;

  latmonCtrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear),
    .arValid(arValid), .arReady(arReady),
    .rValid(rValid), .rReady(rReady),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .overflowFlag(overflowFlag), .orphanFlag(orphanFlag)
  );

  latmonDatapath #(.DEPTH(DEPTH), .TS_W(TS_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr),
    .sampleValid(sampleValid), .sampleLatency(sampleLatency),
    .sampleCount(sampleCount), .minLatency(minLatency),
    .maxLatency(maxLatency), .latencySum(latencySum)
  );
endmodule

// File: tb/test_axiReadLatMon.sv
`timescale 1ns/1ps
module test_axiReadLatMon;
  logic clk = 1'b0;
  logic rstN = 1'b0, clear = 1'b0;
  logic arValid = 1'b0, arReady = 1'b0, rValid = 1'b0, rReady = 1'b0;
  logic sampleValid, overflowFlag, orphanFlag;
  logic [31:0] sampleLatency, sampleCount, minLatency, maxLatency;
  logic [47:0] latencySum;

  int errors = 0, checks = 0;
  longint edges = 0;
  longint expCount = 0, expSum = 0, expMin = 64'hFFFFFFFF, expMax = 0;
  longint reqEdge [16];
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  axiReadLatMon i_axiReadLatMon (
    .clk(clk), .rstN(rstN), .clear(clear),
    .arValid(arValid), .arReady(arReady), .rValid(rValid), .rReady(rReady),
    .sampleValid(sampleValid), .sampleLatency(sampleLatency),
    .sampleCount(sampleCount), .minLatency(minLatency), .maxLatency(maxLatency),
    .latencySum(latencySum), .overflowFlag(overflowFlag), .orphanFlag(orphanFlag)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkStats(input string req);
    chk(sampleCount == expCount[31:0], {req, " count"}, sampleCount, expCount);
    chk(latencySum == expSum[47:0], {req, " sum"}, latencySum, expSum);
    chk(minLatency == expMin[31:0], {req, " min"}, minLatency, expMin);
    chk(maxLatency == expMax[31:0], {req, " max"}, maxLatency, expMax);
  endtask

  task automatic resetStats();
    expCount = 0; expSum = 0; expMin = 64'hFFFFFFFF; expMax = 0;
  endtask

  task automatic doClear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    resetStats();
  endtask

  // One address handshake; returns the edge at which it was taken, ends one idle cycle later
  task automatic arPulse(output longint at);
    arValid = 1'b1; arReady = 1'b1;
    @(negedge clk);
    at = edges;
    arValid = 1'b0; arReady = 1'b0;
    @(negedge clk);
  endtask

  // Burst of back-to-back beats; expects a sample (expLat) or none (expLat < 0)
  task automatic burst(input int beats, input longint expLat, input string req);
    longint lat;
    rValid = 1'b1; rReady = 1'b1;
    @(negedge clk);
    if (expLat >= 0) begin
      lat = expLat;
      expCount++; expSum += lat;
      if (lat < expMin) expMin = lat;
      if (lat > expMax) expMax = lat;
      chk(sampleValid == 1'b1, {req, " strobe"}, sampleValid, 1);
      chk(sampleLatency == lat[31:0], {req, " latency"}, sampleLatency, lat);
    end else begin
      chk(sampleValid == 1'b0, {req, " no strobe"}, sampleValid, 0);
    end
    for (int k = 1; k < beats; k++) begin
      @(negedge clk);
      chk(sampleValid == 1'b0, "R3 later beat", sampleValid, 0);
    end
    rValid = 1'b0; rReady = 1'b0;
    @(negedge clk);
    chkStats(req);
  endtask

  initial begin
    longint t;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sampleValid == 0, "R1 strobe", sampleValid, 0);
    chk(overflowFlag == 0 && orphanFlag == 0, "R1 flags", {overflowFlag, orphanFlag}, 0);
    chkStats("R1");

    // R4/R8 sweep of latency 1..40, 16-beat bursts
    for (int lat = 1; lat <= 40; lat++) begin
      arValid = 1'b1; arReady = 1'b1;
      @(negedge clk);
      t = edges;
      arValid = 1'b0; arReady = 1'b0;
      repeat (lat - 1) @(negedge clk);
      burst(16, edges + 1 - t, "R4");
    end
    // longer delays and full 256-beat burst
    for (int lat = 60; lat <= 300; lat += 120) begin
      arPulse(t);
      repeat (lat) @(negedge clk);
      burst(256, edges + 1 - t, "R8");
    end

    // R3 first beat waits for rReady: no sample
    arPulse(t);
    rValid = 1'b1; rReady = 1'b0;
    @(negedge clk);
    rReady = 1'b1;
    @(negedge clk);
    chk(sampleValid == 0, "R3 late ready", sampleValid, 0);
    rValid = 1'b0; rReady = 1'b0;
    @(negedge clk);
    chkStats("R3");

    // R9 clear restores reset state and empties queue
    doClear();
    chk(overflowFlag == 0 && orphanFlag == 0, "R9 flags", {overflowFlag, orphanFlag}, 0);
    chkStats("R9");
    burst(4, -1, "R9");
    chk(orphanFlag == 1, "R9 orphan after clear", orphanFlag, 1);

    // R2 address valid held while waiting: never timestamped
    doClear();
    arValid = 1'b1; arReady = 1'b0;
    repeat (3) @(negedge clk);
    arReady = 1'b1;
    @(negedge clk);
    arValid = 1'b0; arReady = 1'b0;
    @(negedge clk);
    burst(4, -1, "R2");
    chk(orphanFlag == 1, "R2 orphan", orphanFlag, 1);

    // R5 several outstanding, in order
    doClear();
    for (int i = 0; i < 3; i++) begin
      arPulse(reqEdge[i]);
      @(negedge clk);
    end
    for (int i = 0; i < 3; i++) begin
      repeat (i + 2) @(negedge clk);
      burst(8, edges + 1 - reqEdge[i], "R5");
    end
    chk(orphanFlag == 0, "R5 no orphan", orphanFlag, 0);

    // R6 overflow at the ninth request, then R7 orphan for the ninth response
    doClear();
    for (int i = 0; i < 9; i++) arPulse(reqEdge[i]);
    chk(overflowFlag == 1, "R6 overflow", overflowFlag, 1);
    for (int i = 0; i < 8; i++) burst(2, edges + 1 - reqEdge[i], "R6");
    chk(orphanFlag == 0, "R7 before", orphanFlag, 0);
    burst(2, -1, "R7");
    chk(orphanFlag == 1, "R7 orphan", orphanFlag, 1);
    chk(overflowFlag == 1, "R6 sticky", overflowFlag, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule